// File: doc/BRIEF.md
# Interleaved Memory Bank Arbiter

This block decides, once per major bus cycle, which of several system sections (compute units, an I/O processor, DMA engines) may start an access on each of a set of independent, interleaved memory banks. A major cycle is eight minor slots long; a free-running slot counter advances on each minor tick, and all requests are sampled and resolved only on the tick that lands on slot 0. Sections that aim at different banks are all served in the same major cycle, so instruction fetch from one bank and data access in another proceed together.

Each bank tracks how long it stays busy after an access is started and refuses new starts until that access ends. When several sections contend, the lowest requester index wins. A section that is turned away leaves a reservation on that bank: until that section is itself granted, every section of lower priority is kept off the bank, even when the bank is free and the reserving section is not asking. This keeps a high-priority section from being starved by a stream of lower-priority traffic, and because the order is fixed no deadlock can form.

Grants and lockouts are registered and held for the whole major cycle; each bank gives a one-clock start strobe when an access is launched on it.

Top module: `mem_bank_arbiter`

## Requirements
- R1: After reset the slot counter reads 0, all grant, lockout, bank_start and bank_busy outputs are 0, and no bank holds a reservation, so the lowest-priority requester (highest index) alone asking for any bank is granted at the first evaluation.
- R2: The slot output advances by one, wrapping from 7 to 0, on every clock with minor_tick high and holds otherwise; an evaluation happens only on a minor_tick clock with slot equal to 0, and major_start is high for the one clock after it.
- R3: req_valid and req_bank are looked at only at an evaluation; grant and lockout change only at an evaluation and hold their values for the rest of the major cycle whatever the inputs do.
- R4: A free, unreserved bank asked for by several requesters is granted to the lowest index among them; grant[r] of the winner is set and bank_start[b] of that bank pulses for one clock.
- R5: Requesters that name different free banks in one evaluation are all granted together.
- R6: Every requester that has req_valid high at an evaluation and is not granted sees lockout high for that major cycle; a requester that is not asking gets neither grant nor lockout.
- R7: A bank that starts an access stays busy for ACCESS_MAJORS major cycles: bank_busy is high from the start edge until the evaluation ACCESS_MAJORS cycles later, and any request to it at an evaluation inside that span is locked out.
- R8: While a bank holds a reservation for requester k, any requester with index greater than k is locked out of it even when the bank is free; requesters with index up to k may still be granted it.
- R9: A bank's reservation is taken by the lowest-index requester locked out of it (replacing a reservation of a higher index) and is cleared when the reserving requester is granted that bank.
- R10: Each bank starts at most one access per evaluation and bank_start only follows an evaluation; the number of grants equals the number of bank starts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| minor_tick | input | 1 | Advance one minor slot |
| req_valid | input | NUM_REQ | Request from each section, bit r for requester r |
| req_bank | input | NUM_REQ*BANK_W | Target bank of each requester, requester r in bits [r*BANK_W +: BANK_W] |
| slot | output | 3 | Current minor slot within the major cycle |
| major_start | output | 1 | One-clock pulse after each evaluation |
| grant | output | NUM_REQ | Requester r started an access this major cycle |
| lockout | output | NUM_REQ | Requester r was turned away this major cycle |
| bank_start | output | NUM_BANKS | One-clock strobe: access launched on bank b |
| bank_busy | output | NUM_BANKS | Bank b has an access in progress |

## Verification
The interesting coincidence is a bank whose reservation is being honoured in the same evaluation that it is still busy, or that it is granted to a higher-priority section while the reserving one is absent. The bench provokes this with a directed sequence that keeps one bank contended across consecutive major cycles with a two-cycle access time, so busy refusals, reservation refusals and higher-priority grants land on the same bank in back-to-back evaluations. A behavioural model computes the expected grant, lockout, strobe and busy values every clock, and random traffic with irregular ticks and inputs that change mid-cycle is compared against it.

// File: rtl/mba_pkg.sv
package mba_pkg;
  // Number of minor slots that make one major bus cycle
  localparam int unsigned MINOR_SLOTS = 8;
  localparam int unsigned SLOT_W      = $clog2(MINOR_SLOTS);
endpackage

// File: rtl/mba_slot_timer.sv
module mba_slot_timer
  import mba_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              minor_tick,
  output logic [SLOT_W-1:0] slot_q,
  output logic              eval_o
);

  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(MINOR_SLOTS - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_q <= '0;
    end else if (minor_tick) begin
      slot_q <= (slot_q == LAST_SLOT) ? '0 : slot_q + 1'b1;
    end
  end

  // Arbitration happens on the tick that sits on slot 0
  assign eval_o = minor_tick && (slot_q == '0);

  // R2: slot steps by one per tick and wraps
  p_slot_step_r2: assert property (@(posedge clk) disable iff (rst)
    minor_tick |=> (slot_q == SLOT_W'(($past(slot_q) + 1) % MINOR_SLOTS)));

  // R2: slot holds without a tick
  p_slot_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !minor_tick |=> $stable(slot_q));

endmodule

// File: rtl/mba_arb_core.sv
module mba_arb_core #(
  parameter int unsigned NUM_REQ   = 4,
  parameter int unsigned NUM_BANKS = 8,
  parameter int unsigned BANK_W    = $clog2(NUM_BANKS),
  parameter int unsigned IDX_W     = $clog2(NUM_REQ)
) (
  input  logic [NUM_REQ-1:0]           req_valid,
  input  logic [NUM_REQ*BANK_W-1:0]    req_bank,
  input  logic [NUM_BANKS-1:0]         bank_blocked,
  input  logic [NUM_BANKS-1:0]         res_valid,
  input  logic [NUM_BANKS*IDX_W-1:0]   res_idx,
  output logic [NUM_BANKS*NUM_REQ-1:0] win_vec,
  output logic [NUM_BANKS-1:0]         lose_valid,
  output logic [NUM_BANKS*IDX_W-1:0]   lose_idx
);

  // One resolver per bank; requesters scanned from highest priority (index 0)
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [NUM_REQ-1:0] win_b;
    logic               lose_v_b;
    logic [IDX_W-1:0]   lose_i_b;
    logic               taken;
    logic [IDX_W-1:0]   limit;

    assign limit = res_idx[b*IDX_W +: IDX_W];

    always_comb begin
      win_b    = '0;
      lose_v_b = 1'b0;
      lose_i_b = '0;
      taken    = 1'b0;
      for (int r = 0; r < NUM_REQ; r++) begin
        if (req_valid[r] && (req_bank[r*BANK_W +: BANK_W] == BANK_W'(b))) begin
          if (!taken && !bank_blocked[b] &&
              (!res_valid[b] || (IDX_W'(r) <= limit))) begin
            win_b[r] = 1'b1;
            taken    = 1'b1;
          end else if (!lose_v_b) begin
            lose_v_b = 1'b1;
            lose_i_b = IDX_W'(r);
          end
        end
      end
    end

    assign win_vec[b*NUM_REQ +: NUM_REQ] = win_b;
    assign lose_valid[b]                 = lose_v_b;
    assign lose_idx[b*IDX_W +: IDX_W]    = lose_i_b;
  end

endmodule

// File: rtl/mba_bank_ctl.sv
module mba_bank_ctl #(
  parameter int unsigned NUM_REQ       = 4,
  parameter int unsigned ACCESS_MAJORS = 1,
  parameter int unsigned IDX_W         = $clog2(NUM_REQ)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               eval,
  input  logic [NUM_REQ-1:0] win,
  input  logic               lose_valid,
  input  logic [IDX_W-1:0]   lose_idx,
  output logic               blocked,
  output logic               busy_o,
  output logic               res_valid_q,
  output logic [IDX_W-1:0]   res_idx_q,
  output logic               start_q
);

  localparam int unsigned CNT_W = $clog2(ACCESS_MAJORS + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(ACCESS_MAJORS);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  // Remaining major cycles of the running access, counting the current one
  logic [CNT_W-1:0] busy_cnt_q;
  logic             granted;
  logic             keep_v;
  logic             res_v_next;
  logic [IDX_W-1:0] res_i_next;

  assign granted = |win;
  assign blocked = busy_cnt_q > CNT_ONE;
  assign busy_o  = busy_cnt_q != '0;

  // Reservation update: drop when the owner wins, tighten to a better loser
  always_comb begin
    keep_v     = res_valid_q && !win[res_idx_q];
    res_v_next = keep_v;
    res_i_next = res_idx_q;
    if (lose_valid && (!keep_v || (lose_idx < res_idx_q))) begin
      res_v_next = 1'b1;
      res_i_next = lose_idx;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_cnt_q  <= '0;
      res_valid_q <= 1'b0;
      res_idx_q   <= '0;
      start_q     <= 1'b0;
    end else begin
      start_q <= eval && granted;
      if (eval) begin
        if (granted) begin
          busy_cnt_q <= CNT_LOAD;
        end else if (busy_cnt_q != '0) begin
          busy_cnt_q <= busy_cnt_q - 1'b1;
        end
        res_valid_q <= res_v_next;
        res_idx_q   <= res_i_next;
      end
    end
  end

  // R7: a busy bank launches nothing
  p_busy_refuse_r7: assert property (@(posedge clk) disable iff (rst)
    (eval && blocked) |-> (win == '0));

  // R10: at most one winner per bank
  p_one_winner_r10: assert property (@(posedge clk) disable iff (rst)
    eval |-> $onehot0(win));

  // R8: no requester below the reservation wins
  p_res_rank_r8: assert property (@(posedge clk) disable iff (rst)
    (eval && res_valid_q) |-> ((win >> res_idx_q) <= NUM_REQ'(1)));

endmodule

// File: rtl/mem_bank_arbiter.sv
module mem_bank_arbiter
  import mba_pkg::*;
#(
  parameter int unsigned NUM_REQ       = 4,
  parameter int unsigned NUM_BANKS     = 8,
  parameter int unsigned ACCESS_MAJORS = 1,
  parameter int unsigned BANK_W        = $clog2(NUM_BANKS)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      minor_tick,
  input  logic [NUM_REQ-1:0]        req_valid,
  input  logic [NUM_REQ*BANK_W-1:0] req_bank,
  output logic [SLOT_W-1:0]         slot,
  output logic                      major_start,
  output logic [NUM_REQ-1:0]        grant,
  output logic [NUM_REQ-1:0]        lockout,
  output logic [NUM_BANKS-1:0]      bank_start,
  output logic [NUM_BANKS-1:0]      bank_busy
);

  localparam int unsigned IDX_W = $clog2(NUM_REQ);

  logic                         eval;
  logic [NUM_BANKS-1:0]         bank_blocked;
  logic [NUM_BANKS-1:0]         res_valid;
  logic [NUM_BANKS*IDX_W-1:0]   res_idx;
  logic [NUM_BANKS*NUM_REQ-1:0] win_vec;
  logic [NUM_BANKS-1:0]         lose_valid;
  logic [NUM_BANKS*IDX_W-1:0]   lose_idx;
  logic [NUM_REQ-1:0]           grant_next;
  logic [NUM_REQ-1:0]           grant_q;
  logic [NUM_REQ-1:0]           lockout_q;
  logic                         major_q;

  mba_slot_timer u_timer (
    .clk        (clk),
    .rst        (rst),
    .minor_tick (minor_tick),
    .slot_q     (slot),
    .eval_o     (eval)
  );

  mba_arb_core #(
    .NUM_REQ   (NUM_REQ),
    .NUM_BANKS (NUM_BANKS),
    .BANK_W    (BANK_W),
    .IDX_W     (IDX_W)
  ) u_core (
    .req_valid    (req_valid),
    .req_bank     (req_bank),
    .bank_blocked (bank_blocked),
    .res_valid    (res_valid),
    .res_idx      (res_idx),
    .win_vec      (win_vec),
    .lose_valid   (lose_valid),
    .lose_idx     (lose_idx)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    mba_bank_ctl #(
      .NUM_REQ       (NUM_REQ),
      .ACCESS_MAJORS (ACCESS_MAJORS),
      .IDX_W         (IDX_W)
    ) u_bank (
      .clk         (clk),
      .rst         (rst),
      .eval        (eval),
      .win         (win_vec[b*NUM_REQ +: NUM_REQ]),
      .lose_valid  (lose_valid[b]),
      .lose_idx    (lose_idx[b*IDX_W +: IDX_W]),
      .blocked     (bank_blocked[b]),
      .busy_o      (bank_busy[b]),
      .res_valid_q (res_valid[b]),
      .res_idx_q   (res_idx[b*IDX_W +: IDX_W]),
      .start_q     (bank_start[b])
    );
  end

  // Fold per-bank winners into per-requester grants
  always_comb begin
    grant_next = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      grant_next = grant_next | win_vec[b*NUM_REQ +: NUM_REQ];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      grant_q   <= '0;
      lockout_q <= '0;
      major_q   <= 1'b0;
    end else begin
      major_q <= eval;
      if (eval) begin
        grant_q   <= grant_next;
        lockout_q <= req_valid & ~grant_next;
      end
    end
  end

  assign grant       = grant_q;
  assign lockout     = lockout_q;
  assign major_start = major_q;

  // R3: outcome only moves at an evaluation
  p_hold_outcome_r3: assert property (@(posedge clk) disable iff (rst)
    !eval |=> ($stable(grant_q) && $stable(lockout_q)));

  // R10: strobes only follow an evaluation
  p_start_after_eval_r10: assert property (@(posedge clk) disable iff (rst)
    (bank_start != '0) |-> $past(eval));

  // R4: every grant is matched by exactly one bank strobe
  p_grant_strobe_r4: assert property (@(posedge clk) disable iff (rst)
    major_q |-> ($countones(grant_q) == $countones(bank_start)));

endmodule

// File: tb/mem_bank_arbiter_tb_top.sv
module mem_bank_arbiter_tb_top;
  localparam int NR  = 4;
  localparam int NB  = 8;
  localparam int BW  = 3;
  localparam int ACC = 2;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic             rst;
  logic             minor_tick;
  logic [NR-1:0]    req_valid;
  logic [NR*BW-1:0] req_bank;
  logic [2:0]       slot;
  logic             major_start;
  logic [NR-1:0]    grant;
  logic [NR-1:0]    lockout;
  logic [NB-1:0]    bank_start;
  logic [NB-1:0]    bank_busy;

  mem_bank_arbiter #(
    .NUM_REQ       (NR),
    .NUM_BANKS     (NB),
    .ACCESS_MAJORS (ACC)
  ) dut_i (
    .clk         (clk),
    .rst         (rst),
    .minor_tick  (minor_tick),
    .req_valid   (req_valid),
    .req_bank    (req_bank),
    .slot        (slot),
    .major_start (major_start),
    .grant       (grant),
    .lockout     (lockout),
    .bank_start  (bank_start),
    .bank_busy   (bank_busy)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // Behavioural reference state
  int            m_slot;
  int            m_cnt [NB];
  int            m_res [NB];
  logic [NR-1:0] m_grant, m_lock;
  logic [NB-1:0] m_start, m_busy;
  logic          m_major;

  always @(posedge clk) begin : ref_model
    int winner, lmin, keep;
    bit busy;
    if (rst) begin
      m_slot = 0; m_major = 0; m_start = '0; m_grant = '0; m_lock = '0;
      for (int b = 0; b < NB; b++) begin m_cnt[b] = 0; m_res[b] = -1; end
    end else begin
      m_major = 0;
      m_start = '0;
      if (minor_tick) begin
        if (m_slot == 0) begin
          m_major = 1;
          m_grant = '0;
          for (int b = 0; b < NB; b++) begin
            busy = m_cnt[b] > 1;
            winner = -1;
            lmin = -1;
            for (int r = 0; r < NR; r++) begin
              if (req_valid[r] && int'(req_bank[r*BW +: BW]) == b) begin
                if (winner < 0 && !busy && (m_res[b] < 0 || r <= m_res[b])) winner = r;
                else if (lmin < 0) lmin = r;
              end
            end
            if (winner >= 0) begin
              m_grant[winner] = 1'b1; m_start[b] = 1'b1; m_cnt[b] = ACC;
            end else if (m_cnt[b] > 0) m_cnt[b] = m_cnt[b] - 1;
            keep = (m_res[b] >= 0 && m_res[b] != winner) ? m_res[b] : -1;
            if (lmin >= 0 && (keep < 0 || lmin < keep)) keep = lmin;
            m_res[b] = keep;
          end
          m_lock = req_valid & ~m_grant;
        end
        m_slot = (m_slot + 1) % 8;
      end
    end
    for (int b = 0; b < NB; b++) m_busy[b] = (m_cnt[b] != 0);
  end

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Clock-by-clock comparison against the model
  always @(negedge clk) begin
    if (!done && !rst) begin
      chk("R2", "slot", 32'(slot), 32'(m_slot));
      chk("R2", "major_start", 32'(major_start), 32'(m_major));
      chk("R4", "grant", 32'(grant), 32'(m_grant));
      chk("R6", "lockout", 32'(lockout), 32'(m_lock));
      chk("R10", "bank_start", 32'(bank_start), 32'(m_start));
      chk("R7", "bank_busy", 32'(bank_busy), 32'(m_busy));
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  // Drive one evaluation: wait for slot 0, apply requests, land after the edge
  task automatic step(input logic [3:0] v, input int b0, input int b1, input int b2, input int b3);
    minor_tick = 1'b1;
    while (m_slot != 0) @(negedge clk);
    req_valid = v;
    req_bank  = {BW'(b3), BW'(b2), BW'(b1), BW'(b0)};
    @(negedge clk);
  endtask

  initial begin : stim
    rst = 1'b1; minor_tick = 1'b0; req_valid = '0; req_bank = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "reset slot", 32'(slot), 0);
    chk("R1", "reset grant/lockout", 32'({grant, lockout}), 0);
    chk("R1", "reset busy/start", 32'({bank_busy, bank_start}), 0);

    step(4'b1000, 0, 0, 0, 5);
    chk("R1", "lowest priority granted first", 32'(grant), 32'h8);
    chk("R4", "start on bank 5", 32'(bank_start), 32'h20);
    step(4'b1111, 0, 1, 2, 3);
    chk("R5", "all distinct banks granted", 32'(grant), 32'hF);
    step(4'b0101, 4, 0, 4, 0);
    chk("R4", "contention winner", 32'(grant), 32'h1);
    chk("R6", "contention loser", 32'(lockout), 32'h4);
    step(4'b0100, 0, 0, 4, 0);
    chk("R7", "busy bank refuses", 32'(lockout), 32'h4);
    chk("R7", "bank 4 busy", 32'(bank_busy[4]), 1);
    step(4'b1000, 0, 0, 0, 4);
    chk("R8", "reservation blocks lower", 32'(lockout), 32'h8);
    chk("R8", "no start while reserved", 32'(bank_start), 0);
    step(4'b1010, 0, 4, 0, 4);
    chk("R8", "higher priority passes reservation", 32'(grant), 32'h2);
    step(4'b0100, 0, 0, 4, 0);
    chk("R7", "busy again", 32'(lockout), 32'h4);
    step(4'b0100, 0, 0, 4, 0);
    chk("R9", "reserving requester granted", 32'(grant), 32'h4);
    step(4'b0000, 0, 0, 0, 0);
    step(4'b1000, 0, 0, 0, 4);
    chk("R9", "reservation cleared", 32'(grant), 32'h8);

    // Mid-cycle input changes must not disturb the outcome
    step(4'b0001, 6, 0, 0, 0);
    req_valid = 4'b1110; req_bank = {BW'(6), BW'(6), BW'(6), BW'(0)};
    repeat (3) @(negedge clk);
    chk("R3", "grant held mid-cycle", 32'(grant), 32'h1);
    chk("R3", "lockout held mid-cycle", 32'(lockout), 0);
    minor_tick = 1'b0;
    begin
      logic [2:0] s0;
      s0 = slot;
      repeat (4) @(negedge clk);
      chk("R2", "slot holds without tick", 32'(slot), 32'(s0));
    end

    // Random traffic with irregular ticks and drifting inputs
    for (int i = 0; i < 3000; i++) begin
      minor_tick = ($urandom_range(0, 9) < 7);
      if ($urandom_range(0, 2) == 0) begin
        req_valid = 4'($urandom);
        for (int r = 0; r < NR; r++) req_bank[r*BW +: BW] = BW'($urandom_range(0, 3));
      end
      @(negedge clk);
    end
    finish_run();
  end

endmodule